// File: doc/BRIEF.md
# Serial Transceiver Reset Sequencer

This block brings up one lane of a serial transceiver whose internal transmit and receive elastic buffers are bypassed, so the surrounding logic has to order the transceiver resets itself. It issues a single-cycle transmit reset pulse to the transceiver and waits for the transmit reset-done indication. It then releases the user-side transmit reset, and only after that issues a single-cycle receive reset pulse and waits for the receive reset-done indication before it releases the user-side receive reset.

The two user-side resets hold the downstream MAC transmit and receive datapaths until each direction is ready. Both reset-done inputs are asynchronous to the sequencer clock and pass through a synchronizer first. Once both directions are released the sequencer stays ready until its own reset or the restart input starts a new bring-up. One instance serves one lane on one free-running clock.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst` is 1, and in the cycle after it, `user_tx_rst` and `user_rx_rst` are 1 and `xcvr_tx_rst` and `xcvr_rx_rst` are 0.
- R2: In the first cycle after `rst` has been sampled 0 for one edge, `xcvr_tx_rst` is 1 for exactly one cycle.
- R3: After the transmit pulse, the sequencer holds both user resets at 1 for as long as the synchronized `xcvr_tx_done` reads 0; `xcvr_rx_done` has no effect during this phase.
- R4: `xcvr_tx_done` passes through a synchronizer of `SYNC_STAGES` flops (default 2): `user_tx_rst` falls in the cycle after the third rising clock edge at which `xcvr_tx_done` is sampled 1, counting the first such edge.
- R5: `xcvr_rx_rst` is 1 for exactly one cycle, starting in the same cycle in which `user_tx_rst` falls; it is never 1 while `user_tx_rst` is 1.
- R6: After the receive pulse, `user_rx_rst` stays 1 for as long as the synchronized `xcvr_rx_done` reads 0.
- R7: `user_rx_rst` falls in the cycle after the third rising edge at which `xcvr_rx_done` is sampled 1 while the receive wait is in progress (at least one cycle after the receive pulse); `user_rx_rst` is never 0 while `user_tx_rst` is 1.
- R8: Once both user resets are 0 they stay 0 regardless of the reset-done inputs until `rst` or `restart` is asserted.
- R9: `restart` sampled 1 at an edge puts the sequencer back into its reset state (as R1) for the following cycle, after which the whole sequence runs again from the transmit pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous request to rerun the bring-up sequence |
| xcvr_tx_done | input | 1 | Transmit reset-done from the transceiver (asynchronous) |
| xcvr_rx_done | input | 1 | Receive reset-done from the transceiver (asynchronous) |
| xcvr_tx_rst | output | 1 | Transmit reset pulse to the transceiver |
| xcvr_rx_rst | output | 1 | Receive reset pulse to the transceiver |
| user_tx_rst | output | 1 | Reset holding the user transmit datapath, active high |
| user_rx_rst | output | 1 | Reset holding the user receive datapath, active high |

## Verification
Every output is a decode of the registered state, so each reacts one edge after the input that causes it, except the done inputs, which take three edges: two synchronizer flops and then the state register. The bench drives inputs on the falling edge, queues the output vector due after the next rising edge, and a monitor compares a quarter period after that edge, so every expected value is tied to one specific edge. The done inputs are raised early during the wrong phase and held high across a restart to show that nothing moves before its due edge.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [2:0] {
        SEQ_START    = 3'd0,
        SEQ_TX_PULSE = 3'd1,
        SEQ_TX_WAIT  = 3'd2,
        SEQ_RX_PULSE = 3'd3,
        SEQ_RX_WAIT  = 3'd4,
        SEQ_READY    = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic xcvr_tx;
        logic user_tx;
        logic xcvr_rx;
        logic user_rx;
    } rst_vec_t;

    localparam int DONE_LANES = 2;
    localparam int LANE_TX    = 0;
    localparam int LANE_RX    = 1;

    function automatic rst_vec_t state_to_resets(seq_state_t st);
        rst_vec_t v;
        v.xcvr_tx = (st == SEQ_TX_PULSE);
        v.xcvr_rx = (st == SEQ_RX_PULSE);
        v.user_tx = (st == SEQ_START) || (st == SEQ_TX_PULSE) || (st == SEQ_TX_WAIT);
        v.user_rx = (st != SEQ_READY);
        return v;
    endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
            end
        end
        assign sync_out[b] = chain[LAST];
    end
endmodule

// File: rtl/xrs_fsm.sv
module xrs_fsm
    import xrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       tx_done_s,
    input  logic       rx_done_s,
    output seq_state_t state
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_START:    nxt = SEQ_TX_PULSE;
            SEQ_TX_PULSE: nxt = SEQ_TX_WAIT;
            SEQ_TX_WAIT:  if (tx_done_s) nxt = SEQ_RX_PULSE;
            SEQ_RX_PULSE: nxt = SEQ_RX_WAIT;
            SEQ_RX_WAIT:  if (rx_done_s) nxt = SEQ_READY;
            SEQ_READY:    nxt = SEQ_READY;
            default:      nxt = SEQ_START;
        endcase
        if (restart) nxt = SEQ_START;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_START;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/xrs_decode.sv
module xrs_decode
    import xrs_pkg::*;
(
    input  seq_state_t state,
    output rst_vec_t   resets
);
    always_comb resets = state_to_resets(state);
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
    import xrs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic xcvr_tx_done,
    input  logic xcvr_rx_done,
    output logic xcvr_tx_rst,
    output logic xcvr_rx_rst,
    output logic user_tx_rst,
    output logic user_rx_rst
);
    logic [DONE_LANES-1:0] done_s;
    logic                  tx_done_s;
    logic                  rx_done_s;
    seq_state_t            state;
    rst_vec_t              resets;

    xrs_sync #(.WIDTH(DONE_LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({xcvr_rx_done, xcvr_tx_done}),
        .sync_out (done_s)
    );

    assign tx_done_s = done_s[LANE_TX];
    assign rx_done_s = done_s[LANE_RX];

    xrs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .tx_done_s (tx_done_s),
        .rx_done_s (rx_done_s),
        .state     (state)
    );

    xrs_decode u_dec (
        .state  (state),
        .resets (resets)
    );

    assign xcvr_tx_rst = resets.xcvr_tx;
    assign xcvr_rx_rst = resets.xcvr_rx;
    assign user_tx_rst = resets.user_tx;
    assign user_rx_rst = resets.user_rx;
endmodule

// File: rtl/xcvr_rst_seq_chk.sv
module xcvr_rst_seq_chk (
    input logic clk,
    input logic rst,
    input logic restart,
    input logic tx_done_s,
    input logic rx_done_s,
    input logic xcvr_tx_rst,
    input logic xcvr_rx_rst,
    input logic user_tx_rst,
    input logic user_rx_rst
);
    AST_RESET_HOLDS: assert property (@(posedge clk)
        rst |=> (user_tx_rst && user_rx_rst && !xcvr_tx_rst && !xcvr_rx_rst)); // R1

    AST_TX_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        xcvr_tx_rst |=> !xcvr_tx_rst); // R2

    AST_TX_WAITS_DONE: assert property (@(posedge clk) disable iff (rst)
        (user_tx_rst && !xcvr_tx_rst && !tx_done_s && !restart) |=> user_tx_rst); // R3

    AST_TX_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(user_tx_rst) |-> $past(tx_done_s)); // R4

    AST_RX_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        xcvr_rx_rst |=> !xcvr_rx_rst); // R5

    AST_RX_AFTER_TX: assert property (@(posedge clk) disable iff (rst)
        xcvr_rx_rst |-> !user_tx_rst); // R5

    AST_RX_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(user_rx_rst) |-> $past(rx_done_s)); // R7

    AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        !user_rx_rst |-> !user_tx_rst); // R7

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!user_rx_rst && !restart) |=> !user_rx_rst); // R8

    AST_RESTART_REENTERS: assert property (@(posedge clk) disable iff (rst)
        restart |=> (user_tx_rst && user_rx_rst && !xcvr_tx_rst && !xcvr_rx_rst)); // R9
endmodule

bind xcvr_rst_seq xcvr_rst_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .restart     (restart),
    .tx_done_s   (tx_done_s),
    .rx_done_s   (rx_done_s),
    .xcvr_tx_rst (xcvr_tx_rst),
    .xcvr_rx_rst (xcvr_rx_rst),
    .user_tx_rst (user_tx_rst),
    .user_rx_rst (user_rx_rst)
);

// File: tb/xcvr_rst_seq_test.sv
module xcvr_rst_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    // Expected vector {xcvr_tx_rst, user_tx_rst, xcvr_rx_rst, user_rx_rst}
    localparam logic [3:0] V_START = 4'b0101;
    localparam logic [3:0] V_TXP   = 4'b1101;
    localparam logic [3:0] V_TXW   = 4'b0101;
    localparam logic [3:0] V_RXP   = 4'b0011;
    localparam logic [3:0] V_RXW   = 4'b0001;
    localparam logic [3:0] V_RDY   = 4'b0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic restart = 1'b0;
    logic tx_done = 1'b0;
    logic rx_done = 1'b0;
    logic xcvr_tx_rst, xcvr_rx_rst, user_tx_rst, user_rx_rst;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    logic [3:0] exp_q [$];
    string      tag_q [$];

    xcvr_rst_seq uut (
        .clk          (clk),
        .rst          (rst),
        .restart      (restart),
        .xcvr_tx_done (tx_done),
        .xcvr_rx_done (rx_done),
        .xcvr_tx_rst  (xcvr_tx_rst),
        .xcvr_rx_rst  (xcvr_rx_rst),
        .user_tx_rst  (user_tx_rst),
        .user_rx_rst  (user_rx_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply inputs at the falling edge, queue the vector due after the next rising edge
    task automatic step(input logic r, input logic rs, input logic td, input logic rd,
                        input logic [3:0] exp, input string tag);
        @(negedge clk);
        rst = r; restart = rs; tx_done = td; rx_done = rd;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            logic [3:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {xcvr_tx_rst, user_tx_rst, xcvr_rx_rst, user_rx_rst};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: outputs %b expected %b at %0t", t, a, e, $time);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done_flag && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state held
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, V_START, "R1 reset");
        // R2: single transmit pulse
        step(0, 0, 0, 0, V_TXP, "R2 tx pulse");
        step(0, 0, 0, 0, V_TXW, "R2 tx pulse ends");
        // R3: wait with tx done low, rx done high must not advance
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, V_TXW, "R3 tx wait, rx done ignored");
        step(0, 0, 0, 0, V_TXW, "R3 tx wait");
        // R4: three edges from tx done
        step(0, 0, 1, 0, V_TXW, "R4 sync edge 1");
        step(0, 0, 1, 0, V_TXW, "R4 sync edge 2");
        step(0, 0, 1, 0, V_RXP, "R4 R5 tx release and rx pulse");
        step(0, 0, 1, 0, V_RXW, "R5 rx pulse single");
        // R6: wait for rx done
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, V_RXW, "R6 rx wait");
        // R7: three edges from rx done
        step(0, 0, 1, 1, V_RXW, "R7 sync edge 1");
        step(0, 0, 1, 1, V_RXW, "R7 sync edge 2");
        step(0, 0, 1, 1, V_RDY, "R7 rx release");
        // R8: terminal, done inputs toggled
        step(0, 0, 0, 0, V_RDY, "R8 ready sticky");
        step(0, 0, 1, 0, V_RDY, "R8 ready sticky");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, V_RDY, "R8 ready sticky");
        // R9: restart with done inputs still high
        step(0, 1, 1, 1, V_START, "R9 restart");
        step(0, 0, 0, 1, V_TXP, "R9 tx pulse again");
        step(0, 0, 0, 1, V_TXW, "R9 tx wait");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, V_TXW, "R3 R9 tx wait, rx done ignored");
        step(0, 0, 1, 1, V_TXW, "R4 edge 1");
        step(0, 0, 1, 1, V_TXW, "R4 edge 2");
        step(0, 0, 1, 1, V_RXP, "R5 rx pulse after tx release");
        step(0, 0, 1, 1, V_RXW, "R7 rx wait one cycle minimum");
        step(0, 0, 1, 1, V_RDY, "R7 rx release with early done");
        // R1: reset from ready
        step(1, 0, 1, 1, V_START, "R1 reset from ready");
        step(1, 0, 1, 1, V_START, "R1 reset held");
        step(0, 0, 0, 0, V_TXP, "R2 pulse after reset");
        // R9: restart in the middle of the wait
        step(0, 0, 0, 0, V_TXW, "R3 wait");
        step(0, 1, 0, 0, V_START, "R9 restart mid-sequence");
        step(0, 0, 0, 0, V_TXP, "R9 pulse after restart");
        step(0, 0, 0, 0, V_TXW, "R3 wait after restart");
        @(negedge clk);
        @(negedge clk);
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule